// File: doc/BRIEF.md
# SECDED Memory Word Protector with Error Log

This block guards a 16-bit memory word with a 6-bit check field. On the write side it computes the check field from the outgoing data, and the memory array stores the two together. On the read side it takes the stored 22-bit codeword and recomputes the check field. The recomputed field, XORed with the stored one, forms a syndrome. The block repairs any single flipped data bit and passes a flipped check bit through as harmless. It detects every double-bit error. On an uncorrectable word it sends the data with a deliberately wrong bus parity bit, so the receiver rejects it.

Both the encoder and the read path are combinational, so checking and repair fit inside the ordinary read cycle. A small register records the first error seen: its syndrome, its address and its kind. The syndrome identifies the failing bit position uniquely, so a service engineer can locate the faulty storage device. The entry stays frozen until it is cleared. Any further errors only advance a saturating counter.

Top module: `ecc_word_guard`

## Requirements
- R1: Data bit j is covered by the check bits set in column code col[j], where bit k of the code selects check bit Ck. col[j] is the j-th smallest 6-bit value with exactly three ones, leaving out 7, 21, 42 and 56. C5, C3, C1 and C0 give even parity over their data bits. C4 and C2 give odd parity, so all-zero data encodes to check 6'b010100. `wrCheck` follows `wrData` combinationally.
- R2: Every check bit covers exactly eight data bits, every data bit feeds exactly three check bits, and no two data bits share a column.
- R3: The syndrome is the check field recomputed from `rdData` (with the same polarity), XORed with `rdCheck`. When `rdValid` is high and the syndrome is zero, `busData` equals `rdData` and no flag is raised.
- R4: With `rdValid` high and a syndrome equal to col[j], data bit j is inverted on `busData` and `corrected` is high.
- R5: With `rdValid` high and a syndrome of weight one (a check-bit error), `busData` equals `rdData` and `checkErr` is high.
- R6: With `rdValid` high, these syndromes raise `uncorrectable` and leave `busData` equal to `rdData`: any nonzero even-weight syndrome (so every two-bit error in the 22-bit word), any weight-3 syndrome that is not a column, and any weight-5 syndrome.
- R7: At most one of `corrected`, `checkErr` and `uncorrectable` is high at any time.
- R8: `busParity` equals the XOR of the 16 `busData` bits, except on an uncorrectable word, where it is inverted.
- R9: When `rdValid` is low, `busData` equals `rdData`, `busParity` is its plain XOR, no flag is raised and the log does not change.
- R10: On a clock edge with an erroneous valid read and no entry held, the log captures the syndrome, `rdAddr` and the kind (1 = data bit corrected, 2 = check bit, 3 = uncorrectable). `logValid` is set and `logCount` becomes 0.
- R11: While an entry is held and no clear is requested, the entry does not change. Each further erroneous valid read increments `logCount`, which saturates at all ones.
- R12: `logClear` drops the entry and zeroes `logCount`. If an erroneous valid read arrives in the same cycle, that error becomes the new entry with a count of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrData | input | 16 | Data being written |
| wrCheck | output | 6 | Check field to store with wrData |
| rdValid | input | 1 | A read word is present this cycle |
| rdAddr | input | ADDR_W | Address of the read word |
| rdData | input | 16 | Stored data as read |
| rdCheck | input | 6 | Stored check field as read |
| busData | output | 16 | Corrected data to the bus |
| busParity | output | 1 | Bus parity, inverted on uncorrectable |
| corrected | output | 1 | Single data-bit error repaired |
| checkErr | output | 1 | Single check-bit error seen |
| uncorrectable | output | 1 | Error beyond repair |
| logClear | input | 1 | Drop the logged entry |
| logValid | output | 1 | An entry is held |
| logKind | output | 2 | Kind of the logged error |
| logSyndrome | output | 6 | Syndrome of the logged error |
| logAddr | output | ADDR_W | Address of the logged error |
| logCount | output | CNT_W | Errors seen after the entry |

## Verification
Two cases are hard to reach from the ports. The first is a weight-3 syndrome that matches no column. A single or double flip never produces one, so the bench flips three chosen check bits to get syndrome 7. The second is the log boundary: counter saturation and a clear that lands on the same edge as a new error. The bench reaches these by issuing more than fifteen erroneous reads after capture, and then by pulsing the clear together with a check-bit fault. The code tables are covered by exhaustive sweeps: all 65536 data words, and every single and double flip over a set of data words.

// File: rtl/ecc_pkg.sv
package ecc_pkg;
  localparam int DATA_W = 16;
  localparam int CHK_W = 6;
  localparam int CODE_W = DATA_W + CHK_W;
  localparam logic [CHK_W-1:0] ODD_POL = 6'b010100;

  typedef enum logic [1:0] {
    ERR_NONE = 2'd0, ERR_DATA = 2'd1, ERR_CHECK = 2'd2, ERR_UNCORR = 2'd3
  } errKind_t;

  typedef struct packed {
    logic     flipEn;
    logic     poison;
    logic     capture;
    logic     bump;
    logic     clear;
    errKind_t kind;
  } ctlStrobe_t;

  function automatic int popSix(input int v);
    int n;
    n = 0;
    for (int b = 0; b < CHK_W; b++) n += (v >> b) & 1;
    return n;
  endfunction

  // weight-3 columns, skipping four that together hit each row twice
  function automatic logic [DATA_W*CHK_W-1:0] buildColumns();
    logic [DATA_W*CHK_W-1:0] cols;
    int n;
    cols = '0;
    n = 0;
    for (int v = 0; v < (1 << CHK_W); v++) begin
      if (popSix(v) == 3 && v != 7 && v != 21 && v != 42 && v != 56 && n < DATA_W) begin
        cols[n*CHK_W +: CHK_W] = CHK_W'(v);
        n++;
      end
    end
    return cols;
  endfunction

  localparam logic [DATA_W*CHK_W-1:0] COLS = buildColumns();

  function automatic logic [CHK_W-1:0] encodeWord(input logic [DATA_W-1:0] d);
    logic [CHK_W-1:0] c;
    c = ODD_POL;
    for (int j = 0; j < DATA_W; j++)
      if (d[j]) c ^= COLS[j*CHK_W +: CHK_W];
    return c;
  endfunction
endpackage

// File: rtl/ecc_control.sv
module ecc_control
  import ecc_pkg::*;
(
  input  logic             rdValid,
  input  logic [CHK_W-1:0] syndrome,
  input  logic             colHit,
  input  logic             logValid,
  input  logic             logClear,
  output ctlStrobe_t       strobe
);
  logic [2:0] synWeight;

  always_comb begin
    synWeight = '0;
    for (int b = 0; b < CHK_W; b++) synWeight += {2'b00, syndrome[b]};
  end

  always_comb begin
    strobe.kind = ERR_NONE;
    if (rdValid && syndrome != '0) begin
      if (synWeight == 3'd1)                strobe.kind = ERR_CHECK;
      else if (synWeight == 3'd3 && colHit) strobe.kind = ERR_DATA;
      else                                  strobe.kind = ERR_UNCORR;
    end
    strobe.flipEn  = (strobe.kind == ERR_DATA);
    strobe.poison  = (strobe.kind == ERR_UNCORR);
    strobe.capture = (strobe.kind != ERR_NONE) && (!logValid || logClear);
    strobe.bump    = (strobe.kind != ERR_NONE) && logValid && !logClear;
    strobe.clear   = logClear;
  end
endmodule

// File: rtl/ecc_datapath.sv
module ecc_datapath
  import ecc_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] wrData,
  output logic [CHK_W-1:0]  wrCheck,
  input  logic              rdValid,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] rdData,
  input  logic [CHK_W-1:0]  rdCheck,
  output logic [CHK_W-1:0]  syndrome,
  output logic              colHit,
  input  ctlStrobe_t        strobe,
  input  logic              logClear,
  output logic [DATA_W-1:0] busData,
  output logic              busParity,
  output logic              logValid,
  output errKind_t          logKind,
  output logic [CHK_W-1:0]  logSyndrome,
  output logic [ADDR_W-1:0] logAddr,
  output logic [CNT_W-1:0]  logCount
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [DATA_W-1:0] flipMask;

  assign wrCheck  = encodeWord(wrData);
  assign syndrome = encodeWord(rdData) ^ rdCheck;

  for (genvar j = 0; j < DATA_W; j++) begin : g_locate
    assign flipMask[j] = (syndrome == COLS[j*CHK_W +: CHK_W]);
  end
  assign colHit = |flipMask;

  assign busData   = rdData ^ (flipMask & {DATA_W{strobe.flipEn}});
  assign busParity = (^busData) ^ strobe.poison;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      logValid    <= 1'b0;
      logKind     <= ERR_NONE;
      logSyndrome <= '0;
      logAddr     <= '0;
      logCount    <= '0;
    end else if (strobe.capture) begin
      logValid    <= 1'b1;
      logKind     <= strobe.kind;
      logSyndrome <= syndrome;
      logAddr     <= rdAddr;
      logCount    <= '0;
    end else if (strobe.clear) begin
      logValid <= 1'b0;
      logCount <= '0;
    end else if (strobe.bump && logCount != CNT_MAX) begin
      logCount <= logCount + 1'b1;
    end
  end

  AST_CLEAN_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && syndrome == '0) |-> (busData == rdData && busParity == ^rdData)); // R3
  AST_FIX_ONE_BIT: assert property (@(posedge clk) disable iff (!rstN)
    strobe.flipEn |-> ($countones(busData ^ rdData) == 1)); // R4
  AST_CHECK_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.kind == ERR_CHECK) |-> (busData == rdData)); // R5
  AST_POISON_PARITY: assert property (@(posedge clk) disable iff (!rstN)
    strobe.poison |-> (busParity != ^busData)); // R8
  AST_LOG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (logValid && !logClear) |=> (logValid && $stable(logSyndrome) && $stable(logAddr) && $stable(logKind))); // R11
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (logValid && !logClear && rdValid && syndrome != '0 && logCount != CNT_MAX) |=> (logCount == $past(logCount) + 1'b1)); // R11
  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    (logClear && !(rdValid && syndrome != '0)) |=> (!logValid && logCount == '0)); // R12
endmodule

// File: rtl/ecc_word_guard.sv
module ecc_word_guard
  import ecc_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [15:0]       wrData,
  output logic [5:0]        wrCheck,
  input  logic              rdValid,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [15:0]       rdData,
  input  logic [5:0]        rdCheck,
  output logic [15:0]       busData,
  output logic              busParity,
  output logic              corrected,
  output logic              checkErr,
  output logic              uncorrectable,
  input  logic              logClear,
  output logic              logValid,
  output logic [1:0]        logKind,
  output logic [5:0]        logSyndrome,
  output logic [ADDR_W-1:0] logAddr,
  output logic [CNT_W-1:0]  logCount
);
  ctlStrobe_t       strobe;
  logic [CHK_W-1:0] syndrome;
  logic             colHit;
  errKind_t         logKindE;

  ecc_control u_ctl (
    .rdValid (rdValid),
    .syndrome(syndrome),
    .colHit  (colHit),
    .logValid(logValid),
    .logClear(logClear),
    .strobe  (strobe)
  );

  ecc_datapath #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .wrData     (wrData),
    .wrCheck    (wrCheck),
    .rdValid    (rdValid),
    .rdAddr     (rdAddr),
    .rdData     (rdData),
    .rdCheck    (rdCheck),
    .syndrome   (syndrome),
    .colHit     (colHit),
    .strobe     (strobe),
    .logClear   (logClear),
    .busData    (busData),
    .busParity  (busParity),
    .logValid   (logValid),
    .logKind    (logKindE),
    .logSyndrome(logSyndrome),
    .logAddr    (logAddr),
    .logCount   (logCount)
  );

  assign logKind       = logKindE;
  assign corrected     = (strobe.kind == ERR_DATA);
  assign checkErr      = (strobe.kind == ERR_CHECK);
  assign uncorrectable = (strobe.kind == ERR_UNCORR);

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({corrected, checkErr, uncorrectable})); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !rdValid |-> (busData == rdData && !corrected && !checkErr && !uncorrectable)); // R9
endmodule

// File: tb/tb_ecc_word_guard.sv
module tb_ecc_word_guard;
  localparam int ADDR_W = 10;
  localparam int CNT_W  = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [15:0] wrData = '0;
  logic [5:0]  wrCheck;
  logic rdValid = 1'b0;
  logic [ADDR_W-1:0] rdAddr = '0;
  logic [15:0] rdData = '0;
  logic [5:0]  rdCheck = '0;
  logic [15:0] busData;
  logic busParity, corrected, checkErr, uncorrectable;
  logic logClear = 1'b0;
  logic logValid;
  logic [1:0] logKind;
  logic [5:0] logSyndrome;
  logic [ADDR_W-1:0] logAddr;
  logic [CNT_W-1:0] logCount;

  int vectors = 0;
  int fails = 0;
  int cycles = 0;
  logic [5:0] cols [16];

  ecc_word_guard #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) dut (.*);

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog act=%0d exp=<150000", cycles);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic int pop(input logic [31:0] v);
    int n = 0;
    for (int b = 0; b < 32; b++) n += v[b];
    return n;
  endfunction

  function automatic logic [5:0] mEnc(input logic [15:0] d);
    logic [5:0] c = 6'b010100;
    for (int j = 0; j < 16; j++) if (d[j]) c ^= cols[j];
    return c;
  endfunction

  // model: returns kind, fills expected data
  function automatic int mRead(input logic [15:0] d, input logic [5:0] c, output logic [15:0] od);
    logic [5:0] s;
    s = mEnc(d) ^ c;
    od = d;
    if (s == 0) return 0;
    if (pop({26'd0, s}) == 1) return 2;
    if (pop({26'd0, s}) == 3)
      for (int j = 0; j < 16; j++) if (cols[j] == s) begin od = d ^ (16'd1 << j); return 1; end
    return 3;
  endfunction

  task automatic checkRead(input string req);
    logic [15:0] ed;
    int k;
    k = mRead(rdData, rdCheck, ed);
    check(busData == ed, req, {16'd0, busData}, {16'd0, ed});
    check(busParity == ((^ed) ^ (k == 3)), {req, " parity R8"}, {31'd0, busParity}, {31'd0, (^ed) ^ (k == 3)});
    check({corrected, checkErr, uncorrectable} == {k == 1, k == 2, k == 3}, {req, " flags R7"},
          {29'd0, corrected, checkErr, uncorrectable}, {29'd0, k == 1, k == 2, k == 3});
  endtask

  task automatic checkLog(input string req, input bit v, input logic [1:0] k, input logic [5:0] s,
                          input logic [ADDR_W-1:0] a, input logic [CNT_W-1:0] n);
    check(logValid == v, {req, " valid"}, {31'd0, logValid}, {31'd0, v});
    if (v) begin
      check(logKind == k, {req, " kind"}, {30'd0, logKind}, {30'd0, k});
      check(logSyndrome == s, {req, " syndrome"}, {26'd0, logSyndrome}, {26'd0, s});
      check(logAddr == a, {req, " addr"}, {22'd0, logAddr}, {22'd0, a});
    end
    check(logCount == n, {req, " count"}, {28'd0, logCount}, {28'd0, n});
  endtask

  // one clocked read: drive after negedge, edge captures, sample at next negedge
  task automatic clockRead(input bit v, input logic [ADDR_W-1:0] a, input logic [15:0] d,
                           input logic [5:0] c, input bit clr);
    rdValid = v; rdAddr = a; rdData = d; rdCheck = c; logClear = clr;
    @(negedge clk);
    rdValid = 1'b0; logClear = 1'b0;
  endtask

  initial begin
    int n;
    logic [15:0] d;
    logic [5:0] c;
    logic [21:0] cw;
    int rowCnt [6];
    n = 0;
    for (int v = 0; v < 64; v++)
      if (pop(v) == 3 && v != 7 && v != 21 && v != 42 && v != 56 && n < 16) begin
        cols[n] = 6'(v); n++;
      end

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkLog("R10 reset", 1'b0, 2'd0, 6'd0, '0, '0);
    check(wrCheck == 6'b010100, "R1 zero word", {26'd0, wrCheck}, 32'h14);

    // R2: columns seen at the write port
    for (int k = 0; k < 6; k++) rowCnt[k] = 0;
    for (int j = 0; j < 16; j++) begin
      wrData = 16'd1 << j; #1;
      c = wrCheck ^ 6'b010100;
      check(pop({26'd0, c}) == 3, "R2 column weight", {26'd0, c}, 32'd3);
      for (int k = 0; k < 6; k++) rowCnt[k] += c[k];
      for (int i = 0; i < j; i++)
        if (cols[i] == c) check(1'b0, "R2 distinct column", {26'd0, c}, {26'd0, ~c});
    end
    for (int k = 0; k < 6; k++) check(rowCnt[k] == 8, "R2 row coverage", rowCnt[k], 32'd8);

    // R1: exhaustive encoder sweep
    for (int v = 0; v < 65536; v++) begin
      wrData = 16'(v); #1;
      check(wrCheck == mEnc(16'(v)), "R1 encode", {26'd0, wrCheck}, {26'd0, mEnc(16'(v))});
    end

    // R9: no valid read, corrupted word passes raw
    rdValid = 1'b0; rdData = 16'hA5C3; rdCheck = mEnc(16'hA5C3) ^ 6'b001011; #1;
    check(busData == 16'hA5C3 && !corrected && !checkErr && !uncorrectable && busParity == ^rdData,
          "R9 idle passthrough", {16'd0, busData}, 32'hA5C3);

    // R3..R8 sweeps with valid reads
    logClear = 1'b1;
    rdValid = 1'b1;
    for (int p = 0; p < 48; p++) begin
      d = 16'(p * 16'h9E37) ^ 16'(p << 3);
      cw = {d, mEnc(d)};
      rdData = cw[21:6]; rdCheck = cw[5:0]; #1;
      checkRead("R3 clean");
      for (int a = 0; a < 22; a++) begin
        cw = {d, mEnc(d)} ^ (22'd1 << a);
        rdData = cw[21:6]; rdCheck = cw[5:0]; #1;
        checkRead(a < 6 ? "R5 check flip" : "R4 data flip");
        for (int b = a + 1; b < 22; b++) begin
          cw = {d, mEnc(d)} ^ (22'd1 << a) ^ (22'd1 << b);
          rdData = cw[21:6]; rdCheck = cw[5:0]; #1;
          check(uncorrectable && busData == rdData, "R6 double", {15'd0, uncorrectable, busData},
                {15'd0, 1'b1, rdData});
        end
      end
      // weight-3 syndrome with no column
      rdData = d; rdCheck = mEnc(d) ^ 6'd7; #1;
      check(uncorrectable && busData == d && busParity != ^d, "R6 unmatched weight3",
            {15'd0, uncorrectable, busData}, {15'd0, 1'b1, d});
    end
    rdValid = 1'b0;
    @(negedge clk);
    logClear = 1'b0;
    @(negedge clk);
    checkLog("R12 cleared", 1'b0, 2'd0, 6'd0, '0, '0);

    // R10 capture of a corrected data error
    d = 16'h3C5A;
    clockRead(1'b1, 10'h12A, d ^ 16'h0020, mEnc(d), 1'b0);
    checkLog("R10 capture", 1'b1, 2'd1, cols[5], 10'h12A, 4'd0);

    // R11 later uncorrectable held, counted
    clockRead(1'b1, 10'h301, d ^ 16'h0003, mEnc(d), 1'b0);
    checkLog("R11 hold", 1'b1, 2'd1, cols[5], 10'h12A, 4'd1);

    // clean read does not count
    clockRead(1'b1, 10'h055, d, mEnc(d), 1'b0);
    checkLog("R11 clean no count", 1'b1, 2'd1, cols[5], 10'h12A, 4'd1);

    // R9 invalid erroneous read: no log change
    clockRead(1'b0, 10'h055, d ^ 16'h8000, mEnc(d), 1'b0);
    checkLog("R9 idle no log", 1'b1, 2'd1, cols[5], 10'h12A, 4'd1);

    // R11 saturation
    for (int i = 0; i < 20; i++) clockRead(1'b1, 10'(i), d, mEnc(d) ^ 6'b000001, 1'b0);
    checkLog("R11 saturate", 1'b1, 2'd1, cols[5], 10'h12A, 4'd15);

    // R12 clear with coincident check-bit error
    clockRead(1'b1, 10'h3FF, d, mEnc(d) ^ 6'b100000, 1'b1);
    checkLog("R12 clear+capture", 1'b1, 2'd2, 6'b100000, 10'h3FF, 4'd0);

    // R12 clear alone
    clockRead(1'b0, '0, '0, '0, 1'b1);
    checkLog("R12 clear", 1'b0, 2'd0, 6'd0, '0, 4'd0);

    // R10 uncorrectable capture kind
    clockRead(1'b1, 10'h0F0, d, mEnc(d) ^ 6'b011000, 1'b0);
    checkLog("R10 uncorr kind", 1'b1, 2'd3, 6'b011000, 10'h0F0, 4'd0);

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule